// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block decides, cycle by cycle, how many instructions leave the head of a reorder buffer and when the pipeline front must discard work. It looks at a small window of head entries and reports how many of them retire this cycle. It grants execution to a non-speculative instruction once that instruction is the oldest one in flight. It keeps track of the sequence number of the youngest instruction still valid. Using that value it accepts or rejects redirect requests from the back end, and it broadcasts the surviving squash point to the earlier stages.

A squash can take several cycles to drain from the buffer, so the controller holds a squashing state until the buffer reports that the squash is complete. A trap request starts a fixed countdown. When the countdown ends, the controller broadcasts the squash. The controller also counts buffer occupancy and sends a fresh free-entry count only in cycles when that count changed.

The allocation port is valid/ready. An entry is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while the buffer is full or a squash is draining, and the producer must hold its request until it is taken. The head window is qualified by `head_valid`. `retire_cnt` is its ready-side answer: the lowest `retire_cnt` entries are removed at the next clock edge. All squash, grant and status outputs are plain, registered, one-cycle-pulse signals that cannot be stalled.

Top module: `rob_retire_ctrl`

## Requirements
- R1: In the idle or running state, `retire_cnt` (combinational) equals the number of consecutive entries, starting at head slot 0, that have both `head_valid` and `head_done` set, capped at COMMIT_W. In every other state it is 0.
- R2: When slot 0 is valid, non-speculative and not yet complete in the idle or running state, `ns_go_valid` pulses high for one cycle in the cycle after, with `ns_go_seq` equal to `head_seq`. The same sequence number is not granted again while it stays at the head.
- R3: Each allocation handshake sets the youngest-valid register to `alloc_seq`. A redirect is accepted only if its 16-bit unsigned sequence number is strictly below that register.
- R4: When several accepted redirects arrive in the same cycle, the one with the lowest sequence number is broadcast. On a tie, the lowest port index wins.
- R5: An accepted redirect produces a one-cycle `sq_valid` pulse in the following cycle, carrying that redirect's sequence number, mispredict flag, target and keep flag. Its sequence number becomes the new youngest-valid value, so a later redirect with an equal or higher number is ignored.
- R6: In the squashing state, `retire_cnt` and `alloc_ready` are 0. The state is left only on `rob_sq_done`: to running if occupancy is nonzero afterwards, otherwise to idle.
- R7: `status` encodes idle=0, running=1, squashing=2, trap pending=3, fetch trap pending=4.
- R8: A `trap_req` sampled in the idle or running state enters state 4 if `trap_fetch` is set, otherwise state 3. Exactly TRAP_LAT clock edges after the sampling edge, `sq_valid` rises with `trap_seq` and keep=0, and the state becomes squashing. Nothing retires while a trap is pending.
- R9: An accepted redirect with keep=1 (squash only younger instructions) that arrives during a pending trap is broadcast, but it leaves the trap state and its countdown untouched.
- R10: Occupancy changes by allocations minus retirements minus `rob_sq_removed`. `free_cnt` is DEPTH minus occupancy, registered. `free_upd` pulses only in the cycle after a cycle in which occupancy changed.
- R11: After reset: `status`=0, `free_cnt`=DEPTH, `alloc_ready`=1, and `sq_valid`, `ns_go_valid` and `free_upd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | COMMIT_W | Head window slot holds an instruction (slot 0 oldest) |
| head_done | input | COMMIT_W | Slot has completed execution |
| head_nonspec | input | COMMIT_W | Slot is non-speculative |
| head_seq | input | SEQ_W | Sequence number in slot 0 |
| retire_cnt | output | clog2(COMMIT_W+1) | Entries retiring at the next edge |
| ns_go_valid | output | 1 | Non-speculative issue permission pulse |
| ns_go_seq | output | SEQ_W | Sequence number given permission |
| alloc_valid | input | 1 | New entry offered to the buffer |
| alloc_seq | input | SEQ_W | Sequence number of the offered entry |
| alloc_ready | output | 1 | Entry can be taken this cycle |
| rd_valid | input | NUM_RD | Redirect request per port |
| rd_seq | input | NUM_RD x SEQ_W | Redirect sequence numbers |
| rd_mispred | input | NUM_RD | Redirect comes from a branch mispredict |
| rd_keep | input | NUM_RD | Keep the named instruction and squash only younger ones |
| rd_target | input | NUM_RD x TGT_W | Redirect fetch target |
| trap_req | input | 1 | Trap request |
| trap_fetch | input | 1 | Trap originates at fetch |
| trap_seq | input | SEQ_W | Sequence number to squash from on a trap |
| rob_sq_removed | input | clog2(SQ_RATE+1) | Entries the buffer removed this cycle by squash |
| rob_sq_done | input | 1 | Buffer finished the squash |
| sq_valid | output | 1 | Squash broadcast pulse |
| sq_seq | output | SEQ_W | Squash point |
| sq_keep | output | 1 | Squash point itself survives |
| sq_mispred | output | 1 | Broadcast caused by a mispredict |
| sq_target | output | TGT_W | Redirect target |
| free_upd | output | 1 | Free count changed |
| free_cnt | output | clog2(DEPTH+1) | Free buffer entries |
| status | output | 3 | Controller state code |

## Verification
Three properties are checked on every cycle: no retirement outside the idle and running states, a non-keeping squash broadcast always landing in the squashing state, and the free count moving exactly when its update flag is set. The grant pulse is checked to follow an idle or running cycle, and a pending trap is checked to exit only to squashing. Other behaviours can only be shown by the bench's scenarios. These are the age filter against the youngest-valid value, oldest-wins selection between two simultaneous redirects, the exact trap countdown length, and a keep-type redirect leaving a pending trap running.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  parameter int unsigned RRC_SEQ_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_SQUASH = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } rrc_state_e;
endpackage

// File: rtl/rrc_retire_count.sv
module rrc_retire_count #(
  parameter int unsigned WIDTH = 4
) (
  input  logic                             enable,
  input  logic [WIDTH-1:0]                 valid,
  input  logic [WIDTH-1:0]                 done,
  output logic [$clog2(WIDTH+1)-1:0]       count
);
  localparam int unsigned CW = $clog2(WIDTH+1);

  logic stop;

  // Leading run of complete entries; the first gap ends the run.
  always_comb begin
    count = '0;
    stop  = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!stop && valid[i] && done[i]) count = CW'(i + 1);
      else                              stop  = 1'b1;
    end
    if (!enable) count = '0;
  end
endmodule

// File: rtl/rrc_redirect_pick.sv
module rrc_redirect_pick #(
  parameter int unsigned NUM_RD = 2,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned IDX_W  = (NUM_RD > 1) ? $clog2(NUM_RD) : 1
) (
  input  logic [NUM_RD-1:0]            valid,
  input  logic [NUM_RD-1:0][SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]             limit,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx
);
  logic [SEQ_W-1:0] best;

  // Oldest request strictly older than the limit; ties keep the lower port.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_RD; i++) begin
      if (valid[i] && (seq[i] < limit) && (!hit || (seq[i] < best))) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = seq[i];
      end
    end
  end
endmodule

// File: rtl/rrc_trap_timer.sv
module rrc_trap_timer #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2((LAT > 1) ? LAT : 2);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT - 1);
    end else if (cancel || expire) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
  import rrc_pkg::*;
#(
  parameter int unsigned COMMIT_W = 4,
  parameter int unsigned SEQ_W    = RRC_SEQ_W,
  parameter int unsigned TGT_W    = 32,
  parameter int unsigned NUM_RD   = 2,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned SQ_RATE  = 4,
  parameter int unsigned TRAP_LAT = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [COMMIT_W-1:0]                  head_valid,
  input  logic [COMMIT_W-1:0]                  head_done,
  input  logic [COMMIT_W-1:0]                  head_nonspec,
  input  logic [SEQ_W-1:0]                     head_seq,
  output logic [$clog2(COMMIT_W+1)-1:0]        retire_cnt,
  output logic                                 ns_go_valid,
  output logic [SEQ_W-1:0]                     ns_go_seq,
  input  logic                                 alloc_valid,
  input  logic [SEQ_W-1:0]                     alloc_seq,
  output logic                                 alloc_ready,
  input  logic [NUM_RD-1:0]                    rd_valid,
  input  logic [NUM_RD-1:0][SEQ_W-1:0]         rd_seq,
  input  logic [NUM_RD-1:0]                    rd_mispred,
  input  logic [NUM_RD-1:0]                    rd_keep,
  input  logic [NUM_RD-1:0][TGT_W-1:0]         rd_target,
  input  logic                                 trap_req,
  input  logic                                 trap_fetch,
  input  logic [SEQ_W-1:0]                     trap_seq,
  input  logic [$clog2(SQ_RATE+1)-1:0]         rob_sq_removed,
  input  logic                                 rob_sq_done,
  output logic                                 sq_valid,
  output logic [SEQ_W-1:0]                     sq_seq,
  output logic                                 sq_keep,
  output logic                                 sq_mispred,
  output logic [TGT_W-1:0]                     sq_target,
  output logic                                 free_upd,
  output logic [$clog2(DEPTH+1)-1:0]           free_cnt,
  output logic [2:0]                           status
);
  localparam int unsigned RC_W  = $clog2(COMMIT_W+1);
  localparam int unsigned OCC_W = $clog2(DEPTH+1);
  localparam int unsigned IDX_W = (NUM_RD > 1) ? $clog2(NUM_RD) : 1;

  rrc_state_e        st_q, st_d;
  logic [SEQ_W-1:0]  youngest_q;
  logic [SEQ_W-1:0]  trap_seq_q;
  logic [OCC_W-1:0]  occ_q, occ_d;
  logic              ns_held_q;
  logic [SEQ_W-1:0]  ns_held_seq_q;

  logic run_like, trap_like;
  assign run_like  = (st_q == ST_IDLE) || (st_q == ST_RUN);
  assign trap_like = (st_q == ST_TRAP) || (st_q == ST_FTRAP);

  // Retirement window
  rrc_retire_count #(.WIDTH(COMMIT_W)) u_count (
    .enable (run_like),
    .valid  (head_valid),
    .done   (head_done),
    .count  (retire_cnt)
  );

  // Redirect age filter
  logic             rd_hit;
  logic [IDX_W-1:0] rd_idx;

  rrc_redirect_pick #(.NUM_RD(NUM_RD), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .valid (rd_valid),
    .seq   (rd_seq),
    .limit (youngest_q),
    .hit   (rd_hit),
    .idx   (rd_idx)
  );

  logic             p_keep, p_mispred;
  logic [SEQ_W-1:0] p_seq;
  logic [TGT_W-1:0] p_target;
  assign p_keep    = rd_keep[rd_idx];
  assign p_mispred = rd_mispred[rd_idx];
  assign p_seq     = rd_seq[rd_idx];
  assign p_target  = rd_target[rd_idx];

  // Trap countdown
  logic trap_start, trap_cancel, trap_busy, trap_expire;
  assign trap_start  = run_like && !rd_hit && trap_req;
  assign trap_cancel = trap_like && rd_hit && !p_keep;

  rrc_trap_timer #(.LAT(TRAP_LAT)) u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trap_start),
    .cancel (trap_cancel),
    .busy   (trap_busy),
    .expire (trap_expire)
  );

  logic fire_trap, fire_rd;
  assign fire_trap = trap_like && trap_expire;
  assign fire_rd   = rd_hit && !fire_trap;

  // Allocation handshake and occupancy
  logic alloc_fire;
  assign alloc_ready = (st_q != ST_SQUASH) && (occ_q != OCC_W'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_comb begin
    occ_d = occ_q + OCC_W'(alloc_fire) - OCC_W'(retire_cnt) - OCC_W'(rob_sq_removed);
  end

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_RUN: begin
        if (rd_hit)        st_d = ST_SQUASH;
        else if (trap_req) st_d = trap_fetch ? ST_FTRAP : ST_TRAP;
        else               st_d = (occ_d == '0) ? ST_IDLE : ST_RUN;
      end
      ST_SQUASH: begin
        if (rd_hit)           st_d = ST_SQUASH;
        else if (rob_sq_done) st_d = (occ_d == '0) ? ST_IDLE : ST_RUN;
      end
      ST_TRAP, ST_FTRAP: begin
        if (fire_trap || trap_cancel) st_d = ST_SQUASH;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Non-speculative grant at the head
  logic ns_cand;
  assign ns_cand = run_like && head_valid[0] && head_nonspec[0] && !head_done[0]
                   && !(ns_held_q && (ns_held_seq_q == head_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      youngest_q    <= '0;
      trap_seq_q    <= '0;
      occ_q         <= '0;
      free_cnt      <= OCC_W'(DEPTH);
      free_upd      <= 1'b0;
      sq_valid      <= 1'b0;
      sq_seq        <= '0;
      sq_keep       <= 1'b0;
      sq_mispred    <= 1'b0;
      sq_target     <= '0;
      ns_go_valid   <= 1'b0;
      ns_go_seq     <= '0;
      ns_held_q     <= 1'b0;
      ns_held_seq_q <= '0;
    end else begin
      st_q     <= st_d;
      occ_q    <= occ_d;
      free_cnt <= OCC_W'(DEPTH) - occ_d;
      free_upd <= (occ_d != occ_q);

      if (trap_start) trap_seq_q <= trap_seq;

      sq_valid <= fire_trap || fire_rd;
      if (fire_trap) begin
        sq_seq     <= trap_seq_q;
        sq_keep    <= 1'b0;
        sq_mispred <= 1'b0;
        sq_target  <= '0;
        youngest_q <= trap_seq_q;
      end else if (fire_rd) begin
        sq_seq     <= p_seq;
        sq_keep    <= p_keep;
        sq_mispred <= p_mispred;
        sq_target  <= p_target;
        youngest_q <= p_seq;
      end else if (alloc_fire) begin
        youngest_q <= alloc_seq;
      end

      ns_go_valid <= ns_cand;
      if (ns_cand) begin
        ns_go_seq     <= head_seq;
        ns_held_q     <= 1'b1;
        ns_held_seq_q <= head_seq;
      end else if (!run_like || (retire_cnt != '0)) begin
        ns_held_q     <= 1'b0;
      end
    end
  end

  assign status = st_q;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int unsigned RC_W = 3,
  parameter int unsigned FC_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      status,
  input logic [RC_W-1:0] retire_cnt,
  input logic            sq_valid,
  input logic            sq_keep,
  input logic            free_upd,
  input logic [FC_W-1:0] free_cnt,
  input logic            ns_go_valid
);
  // R1 / R6 / R8: nothing leaves the buffer outside idle and running
  a_r1_no_retire_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (status > 3'd1) |-> (retire_cnt == '0));

  // R10: the flag marks exactly the cycles where the count moved
  a_r10_upd_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    free_upd |-> (free_cnt != $past(free_cnt)));

  a_r10_quiet_means_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !free_upd |-> $stable(free_cnt));

  // R2: grants only follow a cycle in idle or running
  a_r2_grant_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    ns_go_valid |-> ($past(status) <= 3'd1));

  // R5 / R8: a full squash broadcast always lands in the squashing state
  a_r5_flush_enters_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !sq_keep) |-> (status == 3'd2));

  // R8: a pending trap exits only to squashing
  a_r8_trap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd3) |=> ((status == 3'd3) || (status == 3'd2)));
endmodule

bind rob_retire_ctrl rrc_checker #(.RC_W(RC_W), .FC_W(OCC_W)) i_rrc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .status      (status),
  .retire_cnt  (retire_cnt),
  .sq_valid    (sq_valid),
  .sq_keep     (sq_keep),
  .free_upd    (free_upd),
  .free_cnt    (free_cnt),
  .ns_go_valid (ns_go_valid)
);

// File: tb/test_rob_retire_ctrl.sv
module test_rob_retire_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]       head_valid = '0, head_done = '0, head_nonspec = '0;
  logic [15:0]      head_seq = '0;
  logic [2:0]       retire_cnt;
  logic             ns_go_valid;
  logic [15:0]      ns_go_seq;
  logic             alloc_valid = 1'b0;
  logic [15:0]      alloc_seq = '0;
  logic             alloc_ready;
  logic [1:0]       rd_valid = '0, rd_mispred = '0, rd_keep = '0;
  logic [1:0][15:0] rd_seq = '0;
  logic [1:0][31:0] rd_target = '0;
  logic             trap_req = 1'b0, trap_fetch = 1'b0;
  logic [15:0]      trap_seq = '0;
  logic [2:0]       rob_sq_removed = '0;
  logic             rob_sq_done = 1'b0;
  logic             sq_valid, sq_keep, sq_mispred;
  logic [15:0]      sq_seq;
  logic [31:0]      sq_target;
  logic             free_upd;
  logic [5:0]       free_cnt;
  logic [2:0]       status;

  rob_retire_ctrl i_rob_retire_ctrl (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_done(head_done), .head_nonspec(head_nonspec),
    .head_seq(head_seq), .retire_cnt(retire_cnt),
    .ns_go_valid(ns_go_valid), .ns_go_seq(ns_go_seq),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready),
    .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_mispred(rd_mispred),
    .rd_keep(rd_keep), .rd_target(rd_target),
    .trap_req(trap_req), .trap_fetch(trap_fetch), .trap_seq(trap_seq),
    .rob_sq_removed(rob_sq_removed), .rob_sq_done(rob_sq_done),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_keep(sq_keep),
    .sq_mispred(sq_mispred), .sq_target(sq_target),
    .free_upd(free_upd), .free_cnt(free_cnt), .status(status)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // {valid[3:0], done[3:0], expected retire count[2:0]}
  localparam logic [10:0] RET_VEC [8] = '{
    {4'b1111, 4'b1111, 3'd4},
    {4'b1111, 4'b0111, 3'd3},
    {4'b1111, 4'b1011, 3'd2},
    {4'b1111, 4'b1110, 3'd0},
    {4'b0011, 4'b1111, 3'd2},
    {4'b0001, 4'b0001, 3'd1},
    {4'b0000, 4'b1111, 3'd0},
    {4'b0101, 4'b1111, 3'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    nxt();
    // R11 reset state
    chk("R11 status", status, 0);
    chk("R11 free_cnt", free_cnt, 32);
    chk("R11 free_upd", free_upd, 0);
    chk("R11 sq_valid", sq_valid, 0);
    chk("R11 ns_go_valid", ns_go_valid, 0);
    chk("R11 alloc_ready", alloc_ready, 1);

    // R1 retire window table
    foreach (RET_VEC[i]) begin
      head_valid = RET_VEC[i][10:7];
      head_done  = RET_VEC[i][6:3];
      #1;
      chk("R1 retire_cnt", retire_cnt, RET_VEC[i][2:0]);
      head_valid = '0;
      nxt();
    end

    // R10 / R3 allocation and free count
    alloc_valid = 1'b1; alloc_seq = 16'd10;
    nxt();
    alloc_valid = 1'b0;
    chk("R10 free_upd after alloc", free_upd, 1);
    chk("R10 free_cnt after alloc", free_cnt, 31);
    chk("R7 running code", status, 1);
    nxt();
    chk("R10 free_upd quiet", free_upd, 0);
    alloc_valid = 1'b1; alloc_seq = 16'd11;
    nxt();
    alloc_seq = 16'd12;
    nxt();
    alloc_valid = 1'b0;

    // R2 non-speculative grant
    head_valid = 4'b0001; head_nonspec = 4'b0001; head_done = '0; head_seq = 16'd10;
    nxt();
    chk("R2 grant pulse", ns_go_valid, 1);
    chk("R2 grant seq", ns_go_seq, 10);
    nxt();
    chk("R2 no repeat grant", ns_go_valid, 0);
    head_valid = '0; head_nonspec = '0;

    // R3 equal to youngest is rejected
    rd_valid = 2'b01; rd_seq[0] = 16'd12;
    nxt();
    rd_valid = '0;
    chk("R3 reject not older", sq_valid, 0);
    chk("R3 still running", status, 1);

    // R4 / R5 two redirects, older on port 1 wins
    rd_valid = 2'b11;
    rd_seq[0] = 16'd11; rd_mispred[0] = 1'b1; rd_target[0] = 32'h0000_ABCD;
    rd_seq[1] = 16'd10; rd_mispred[1] = 1'b0; rd_target[1] = 32'h0000_1234;
    nxt();
    rd_valid = '0;
    chk("R5 squash pulse", sq_valid, 1);
    chk("R4 older seq wins", sq_seq, 10);
    chk("R4 winner target", sq_target, 32'h1234);
    chk("R5 mispred flag", sq_mispred, 0);
    chk("R6 squashing code", status, 2);
    // R6 blocked during squash
    head_valid = 4'b0001; head_done = 4'b0001;
    #1;
    chk("R6 no retire", retire_cnt, 0);
    chk("R6 alloc blocked", alloc_ready, 0);
    head_valid = '0; head_done = '0;
    rd_valid = 2'b01; rd_seq[0] = 16'd10;
    nxt();
    rd_valid = '0;
    chk("R5 single cycle pulse", sq_valid, 0);
    chk("R6 held squashing", status, 2);
    rob_sq_removed = 3'd2; rob_sq_done = 1'b1;
    nxt();
    rob_sq_removed = '0; rob_sq_done = 1'b0;
    chk("R6 back to running", status, 1);
    chk("R10 free after removal", free_cnt, 31);
    chk("R10 upd after removal", free_upd, 1);

    // R8 fetch trap countdown
    trap_req = 1'b1; trap_fetch = 1'b1; trap_seq = 16'd9;
    nxt();
    trap_req = 1'b0; trap_fetch = 1'b0;
    chk("R8 fetch trap code", status, 4);
    head_valid = 4'b0001; head_done = 4'b0001;
    #1;
    chk("R8 no retire pending", retire_cnt, 0);
    head_valid = '0; head_done = '0;
    for (int k = 1; k < 4; k++) begin
      nxt();
      chk("R8 no early squash", sq_valid, 0);
    end
    nxt();
    chk("R8 squash at latency", sq_valid, 1);
    chk("R8 trap seq", sq_seq, 9);
    chk("R8 trap keep", sq_keep, 0);
    chk("R8 into squashing", status, 2);
    rob_sq_removed = 3'd1; rob_sq_done = 1'b1;
    nxt();
    rob_sq_removed = '0; rob_sq_done = 1'b0;
    chk("R6 to idle when empty", status, 0);
    chk("R10 free full", free_cnt, 32);

    // R9 keep redirect during trap
    alloc_valid = 1'b1; alloc_seq = 16'd20;
    nxt();
    alloc_valid = 1'b0;
    trap_req = 1'b1; trap_seq = 16'd20;
    nxt();
    trap_req = 1'b0;
    chk("R8 trap code", status, 3);
    rd_valid = 2'b01; rd_seq[0] = 16'd15; rd_keep[0] = 1'b1;
    nxt();
    rd_valid = '0; rd_keep = '0;
    chk("R9 keep broadcast", sq_valid, 1);
    chk("R9 keep flag", sq_keep, 1);
    chk("R9 keep seq", sq_seq, 15);
    chk("R9 trap stays", status, 3);
    for (int k = 2; k < 4; k++) begin
      nxt();
      chk("R9 countdown continues", sq_valid, 0);
    end
    nxt();
    chk("R9 trap fires on time", sq_valid, 1);
    chk("R9 trap fire seq", sq_seq, 20);
    chk("R9 squashing after trap", status, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule